// File: doc/BRIEF.md
# USB Endpoint Bank Status Tracker

This block keeps the buffer-bank bookkeeping for one endpoint of a high-speed USB device controller. An endpoint may own one, two or three data banks. The packet engine reports bus-side events (host OUT data stored, IN packet transmitted, NAK handshake returned, setup packet stored, microframe boundary). Firmware reports its own actions (a bank marked ready to send, a received bank released, NAK flag clear, endpoint reset, endpoint disable). From these single-cycle strobes the tracker keeps the index of the bank firmware should touch next, the number of occupied banks, a sticky NAK-sent flag and a flush-error flag.

On a control endpoint the two-bit bank field carries the data-stage direction of the latest setup request instead of a bank index. Endpoint type, direction, bank count and the high-bandwidth isochronous property are quasi-static configuration inputs. They are changed only together with an endpoint reset or disable strobe.

Top module: `usb_bank_tracker`

## Requirements
- R1: The bank field `st_bank` only ever reads 0, 1 or 2 (bank 0 or single bank, bank 1, bank 2). The code 3 is never produced.
- R2: On a non-control endpoint the bank index moves to the next bank on `fw_pkt_ready` when `cfg_dir_in`=1, and on `fw_rx_ack` when `cfg_dir_in`=0. From the last configured bank it wraps to 0, so with one bank it stays at 0. A `cfg_banks` of 0 behaves as 1.
- R3: `st_busy` counts occupied banks. On an IN endpoint firmware fills with `fw_pkt_ready` and `ev_in_sent` empties. On an OUT endpoint `ev_out_rx` fills and `fw_rx_ack` empties. The count saturates at the configured bank count and at zero. A fill and an empty in the same cycle leave it unchanged.
- R4: With `cfg_ctrl`=1, `st_bank` reads 0 for a control write and 1 for a control read. The value is taken from bit 7 of `setup_byte` on each `ev_setup`, and the bank index does not advance.
- R5: `st_nak` sets the cycle after `ev_nak` and clears the cycle after `fw_nak_clr`. When both arrive together it ends up set.
- R6: On an IN, non-control endpoint with `cfg_hb_iso`=1, `ev_uframe_end` while `st_busy` is nonzero clears `st_busy` and sets the sticky `st_flush_err`. In every other case `ev_uframe_end` has no effect.
- R7: `fw_ep_reset` or `fw_ep_disable` clears the bank index, `st_busy`, `st_nak` and `st_flush_err` on the next cycle, overriding any other event in the same cycle. The control direction is kept.
- R8: Synchronous reset `rst` clears every state item, including the control direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_banks | input | 2 | Configured bank count (1..3, 0 treated as 1) |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_ctrl | input | 1 | 1 = control endpoint |
| cfg_hb_iso | input | 1 | 1 = high-bandwidth isochronous endpoint |
| ev_out_rx | input | 1 | Host OUT data stored into a bank |
| ev_in_sent | input | 1 | IN packet sent from a bank |
| ev_nak | input | 1 | NAK returned to an OUT or PING token |
| ev_setup | input | 1 | New setup packet stored |
| setup_byte | input | 8 | First byte of the setup data |
| ev_uframe_end | input | 1 | End of microframe |
| fw_pkt_ready | input | 1 | Firmware marks an IN bank ready |
| fw_rx_ack | input | 1 | Firmware releases a received OUT bank |
| fw_nak_clr | input | 1 | Firmware clears the NAK-sent flag |
| fw_ep_reset | input | 1 | Endpoint reset strobe |
| fw_ep_disable | input | 1 | Endpoint disable strobe |
| st_bank | output | 2 | Current bank index, or control direction |
| st_busy | output | 2 | Number of busy banks |
| st_nak | output | 1 | NAK-sent flag |
| st_flush_err | output | 1 | Flush-error flag |

## Verification
The assertions run on every cycle. They check that the bank code 3 never appears and that the busy count never exceeds the configured bank count. They check that a single-bank endpoint stays on bank 0, and that endpoint reset and disable clear state one cycle later. They also check that the NAK priority holds, that a flush zeroes the count and raises the error flag, and that a setup strobe loads the direction. Only the bench's scenarios can show the full rotation order across two and three banks, saturation against a mixed stream of fills and empties, the floor at zero, and the control direction surviving an endpoint reset. The same holds for `ev_uframe_end` having no effect on endpoints that are not high-bandwidth isochronous IN.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  typedef enum logic [1:0] {
    BUSY_HOLD = 2'd0,
    BUSY_INC  = 2'd1,
    BUSY_DEC  = 2'd2,
    BUSY_ZERO = 2'd3
  } busy_op_e;
endpackage

// File: rtl/ubt_bank_ptr.sv
module ubt_bank_ptr #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic [IDX_W-1:0] last,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_q;

  // Round-robin walk over banks 0..last.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx_q <= '0;
    end else if (adv) begin
      if (idx_q >= last) idx_q <= '0;
      else               idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign idx = idx_q;
endmodule

// File: rtl/ubt_busy_cnt.sv
module ubt_busy_cnt
  import ubt_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  busy_op_e         op,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      unique case (op)
        BUSY_ZERO: cnt_q <= '0;
        BUSY_INC:  if (cnt_q < limit) cnt_q <= cnt_q + CNT_W'(1);
        BUSY_DEC:  if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ubt_flags.sv
module ubt_flags (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic nak_set,
  input  logic nak_clr,
  input  logic ferr_set,
  output logic nak,
  output logic ferr
);
  logic nak_q, ferr_q;

  // Endpoint clear dominates; for NAK a set beats a firmware clear.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      nak_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      if (nak_set)      nak_q <= 1'b1;
      else if (nak_clr) nak_q <= 1'b0;
      if (ferr_set)     ferr_q <= 1'b1;
    end
  end

  assign nak  = nak_q;
  assign ferr = ferr_q;
endmodule

// File: rtl/usb_bank_tracker.sv
module usb_bank_tracker
  import ubt_pkg::*;
#(
  parameter int MAX_BANKS = 3,
  localparam int IDX_W = $clog2(MAX_BANKS),
  localparam int CNT_W = $clog2(MAX_BANKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_banks,
  input  logic             cfg_dir_in,
  input  logic             cfg_ctrl,
  input  logic             cfg_hb_iso,
  input  logic             ev_out_rx,
  input  logic             ev_in_sent,
  input  logic             ev_nak,
  input  logic             ev_setup,
  input  logic [7:0]       setup_byte,
  input  logic             ev_uframe_end,
  input  logic             fw_pkt_ready,
  input  logic             fw_rx_ack,
  input  logic             fw_nak_clr,
  input  logic             fw_ep_reset,
  input  logic             fw_ep_disable,
  output logic [IDX_W-1:0] st_bank,
  output logic [CNT_W-1:0] st_busy,
  output logic             st_nak,
  output logic             st_flush_err
);
  logic [CNT_W-1:0] nb;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] idx;
  logic             ep_clr;
  logic             fill, empty, adv, flush;
  logic             ctl_dir_q;
  busy_op_e         op;

  // Effective bank count, clamped to 1..MAX_BANKS.
  always_comb begin
    if (cfg_banks == '0)                     nb = CNT_W'(1);
    else if (cfg_banks > CNT_W'(MAX_BANKS))  nb = CNT_W'(MAX_BANKS);
    else                                     nb = cfg_banks;
  end
  assign last_idx = IDX_W'(nb - CNT_W'(1));

  assign ep_clr = fw_ep_reset | fw_ep_disable;
  assign fill   = cfg_dir_in ? fw_pkt_ready : ev_out_rx;
  assign empty  = cfg_dir_in ? ev_in_sent   : fw_rx_ack;
  assign adv    = ~cfg_ctrl & (cfg_dir_in ? fw_pkt_ready : fw_rx_ack);
  assign flush  = ev_uframe_end & cfg_hb_iso & cfg_dir_in & ~cfg_ctrl
                & (st_busy != '0);

  always_comb begin
    if (ep_clr || flush)    op = BUSY_ZERO;
    else if (fill && !empty) op = BUSY_INC;
    else if (empty && !fill) op = BUSY_DEC;
    else                     op = BUSY_HOLD;
  end

  ubt_bank_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .clr  (ep_clr),
    .adv  (adv),
    .last (last_idx),
    .idx  (idx)
  );

  ubt_busy_cnt #(.CNT_W(CNT_W)) u_busy (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .limit (nb),
    .cnt   (st_busy)
  );

  ubt_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .clr      (ep_clr),
    .nak_set  (ev_nak),
    .nak_clr  (fw_nak_clr),
    .ferr_set (flush),
    .nak      (st_nak),
    .ferr     (st_flush_err)
  );

  // Control data-stage direction, kept across endpoint reset.
  always_ff @(posedge clk) begin
    if (rst)                      ctl_dir_q <= 1'b0;
    else if (ev_setup && cfg_ctrl) ctl_dir_q <= setup_byte[7];
  end

  assign st_bank = cfg_ctrl ? IDX_W'(ctl_dir_q) : idx;
endmodule

// File: rtl/ubt_checker.sv
module ubt_checker #(
  parameter int MAX_BANKS = 3,
  localparam int IDX_W = $clog2(MAX_BANKS),
  localparam int CNT_W = $clog2(MAX_BANKS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cfg_banks,
  input logic             cfg_dir_in,
  input logic             cfg_ctrl,
  input logic             cfg_hb_iso,
  input logic             ev_nak,
  input logic             ev_setup,
  input logic [7:0]       setup_byte,
  input logic             ev_uframe_end,
  input logic             fw_nak_clr,
  input logic             fw_ep_reset,
  input logic             fw_ep_disable,
  input logic [IDX_W-1:0] st_bank,
  input logic [CNT_W-1:0] st_busy,
  input logic             st_nak,
  input logic             st_flush_err
);
  logic [CNT_W-1:0] lim;
  logic             clr;
  assign lim = (cfg_banks == '0) ? CNT_W'(1)
             : (cfg_banks > CNT_W'(MAX_BANKS)) ? CNT_W'(MAX_BANKS) : cfg_banks;
  assign clr = fw_ep_reset | fw_ep_disable;

  a_r1_no_invalid_code: assert property (@(posedge clk) disable iff (rst)
    st_bank != IDX_W'(3));

  a_r2_single_bank_fixed: assert property (@(posedge clk) disable iff (rst)
    ($stable(cfg_banks) && $stable(cfg_ctrl) && lim == CNT_W'(1) && !cfg_ctrl)
      |-> st_bank == '0);

  a_r3_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    $stable(cfg_banks) |-> st_busy <= lim);

  a_r4_setup_dir: assert property (@(posedge clk) disable iff (rst)
    (cfg_ctrl && ev_setup) |=>
      (!cfg_ctrl || st_bank == IDX_W'($past(setup_byte[7]))));

  a_r5_nak_set: assert property (@(posedge clk) disable iff (rst)
    (ev_nak && !clr) |=> st_nak);

  a_r5_nak_clear: assert property (@(posedge clk) disable iff (rst)
    (fw_nak_clr && !ev_nak) |=> !st_nak);

  a_r6_flush: assert property (@(posedge clk) disable iff (rst)
    (ev_uframe_end && cfg_hb_iso && cfg_dir_in && !cfg_ctrl &&
     st_busy != '0 && !clr) |=> (st_flush_err && st_busy == '0));

  a_r7_ep_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (st_busy == '0 && !st_nak && !st_flush_err &&
             (cfg_ctrl || st_bank == '0)));
endmodule

bind usb_bank_tracker ubt_checker #(.MAX_BANKS(MAX_BANKS)) u_chk (.*);

// File: tb/tb_usb_bank_tracker.sv
module tb_usb_bank_tracker;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0] cfg_banks = 2'd3;
  logic cfg_dir_in = 1'b1, cfg_ctrl = 1'b0, cfg_hb_iso = 1'b0;
  logic ev_out_rx = 0, ev_in_sent = 0, ev_nak = 0, ev_setup = 0, ev_uframe_end = 0;
  logic [7:0] setup_byte = 8'h00;
  logic fw_pkt_ready = 0, fw_rx_ack = 0, fw_nak_clr = 0, fw_ep_reset = 0, fw_ep_disable = 0;
  logic [1:0] st_bank, st_busy;
  logic st_nak, st_flush_err;

  usb_bank_tracker dut (.*);

  int checks = 0, errors = 0;
  int m_bank = 0, m_busy = 0, m_nak = 0, m_ferr = 0, m_dir = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int nb = (cfg_banks == 0) ? 1 : int'(cfg_banks);
    bit clr  = fw_ep_reset || fw_ep_disable;
    bit fill = cfg_dir_in ? fw_pkt_ready : ev_out_rx;
    bit emp  = cfg_dir_in ? ev_in_sent : fw_rx_ack;
    bit adv  = !cfg_ctrl && (cfg_dir_in ? fw_pkt_ready : fw_rx_ack);
    bit fl   = ev_uframe_end && cfg_hb_iso && cfg_dir_in && !cfg_ctrl && m_busy > 0;
    if (ev_setup && cfg_ctrl) m_dir = int'(setup_byte[7]);
    if (clr) begin
      m_bank = 0; m_busy = 0; m_nak = 0; m_ferr = 0;
    end else begin
      if (adv) m_bank = (m_bank + 1) % nb;
      if (fl) begin m_busy = 0; m_ferr = 1; end
      else if (fill && !emp && m_busy < nb) m_busy++;
      else if (emp && !fill && m_busy > 0) m_busy--;
      if (ev_nak) m_nak = 1;
      else if (fw_nak_clr) m_nak = 0;
    end
  endtask

  task automatic compare();
    chk("R2/R4 bank field", int'(st_bank), cfg_ctrl ? m_dir : m_bank);
    chk("R1 bank code legal", int'(st_bank != 2'd3), 1);
    chk("R3 busy count", int'(st_busy), m_busy);
    chk("R5 nak flag", int'(st_nak), m_nak);
    chk("R6 flush error", int'(st_flush_err), m_ferr);
  endtask

  task automatic clear_strobes();
    ev_out_rx = 0; ev_in_sent = 0; ev_nak = 0; ev_setup = 0; ev_uframe_end = 0;
    fw_pkt_ready = 0; fw_rx_ack = 0; fw_nak_clr = 0; fw_ep_reset = 0; fw_ep_disable = 0;
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    clear_strobes();
  endtask

  task automatic setup_ep(bit dir_in, bit ctrl, bit hb, logic [1:0] banks);
    cfg_dir_in = dir_in; cfg_ctrl = ctrl; cfg_hb_iso = hb; cfg_banks = banks;
    fw_ep_reset = 1;
    cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 reset bank", int'(st_bank), 0);
    chk("R8 reset busy", int'(st_busy), 0);
    chk("R8 reset nak", int'(st_nak), 0);
    chk("R8 reset ferr", int'(st_flush_err), 0);
    rst = 0;

    // R2 R3: IN endpoint, three banks
    setup_ep(1, 0, 0, 2'd3);
    repeat (3) begin fw_pkt_ready = 1; cycle(); end
    chk("R2 wrap after three", int'(st_bank), 0);
    chk("R3 busy full", int'(st_busy), 3);
    fw_pkt_ready = 1; cycle();
    chk("R3 saturate at bank count", int'(st_busy), 3);
    chk("R2 advance past wrap", int'(st_bank), 1);
    ev_in_sent = 1; cycle();
    chk("R3 empty decrements", int'(st_busy), 2);
    fw_pkt_ready = 1; ev_in_sent = 1; cycle();
    chk("R3 fill and empty together", int'(st_busy), 2);
    chk("R2 bank two", int'(st_bank), 2);

    // R2 R3: OUT endpoint, two banks
    setup_ep(0, 0, 0, 2'd2);
    repeat (3) begin ev_out_rx = 1; cycle(); end
    chk("R3 OUT saturate at 2", int'(st_busy), 2);
    chk("R2 OUT fill does not move bank", int'(st_bank), 0);
    repeat (3) begin fw_rx_ack = 1; cycle(); end
    chk("R3 floor at zero", int'(st_busy), 0);
    chk("R2 two-bank wrap", int'(st_bank), 1);

    // R2: single bank, and zero treated as one
    setup_ep(1, 0, 0, 2'd1);
    repeat (2) begin fw_pkt_ready = 1; cycle(); end
    chk("R2 single bank stays 0", int'(st_bank), 0);
    chk("R3 single bank busy 1", int'(st_busy), 1);
    setup_ep(1, 0, 0, 2'd0);
    repeat (2) begin fw_pkt_ready = 1; cycle(); end
    chk("R2 zero count as one bank", int'(st_bank), 0);

    // R4 R7: control endpoint
    setup_ep(0, 1, 0, 2'd1);
    ev_setup = 1; setup_byte = 8'h80; cycle();
    chk("R4 control read", int'(st_bank), 1);
    ev_setup = 1; setup_byte = 8'h21; cycle();
    chk("R4 control write", int'(st_bank), 0);
    ev_setup = 1; setup_byte = 8'hC1; cycle();
    fw_rx_ack = 1; cycle();
    chk("R4 no advance on control", int'(st_bank), 1);
    fw_ep_reset = 1; cycle();
    chk("R7 direction kept", int'(st_bank), 1);

    // R5: NAK flag
    setup_ep(0, 0, 0, 2'd2);
    ev_nak = 1; cycle();
    chk("R5 nak set", int'(st_nak), 1);
    ev_nak = 1; fw_nak_clr = 1; cycle();
    chk("R5 set wins over clear", int'(st_nak), 1);
    fw_nak_clr = 1; cycle();
    chk("R5 nak cleared", int'(st_nak), 0);

    // R6: flush on high-bandwidth isochronous IN
    setup_ep(1, 0, 1, 2'd3);
    repeat (2) begin fw_pkt_ready = 1; cycle(); end
    ev_uframe_end = 1; cycle();
    chk("R6 flush clears busy", int'(st_busy), 0);
    chk("R6 flush sets error", int'(st_flush_err), 1);
    ev_uframe_end = 1; cycle();
    chk("R6 error sticky", int'(st_flush_err), 1);
    ev_nak = 1; fw_pkt_ready = 1; fw_ep_disable = 1; cycle();
    chk("R7 disable clears error", int'(st_flush_err), 0);
    chk("R7 disable beats fill", int'(st_busy), 0);
    chk("R7 disable beats nak", int'(st_nak), 0);
    chk("R7 disable clears bank", int'(st_bank), 0);
    setup_ep(1, 0, 0, 2'd3);
    fw_pkt_ready = 1; cycle();
    ev_uframe_end = 1; cycle();
    chk("R6 no flush without hb iso", int'(st_busy), 1);
    chk("R6 no error without hb iso", int'(st_flush_err), 0);

    // Random traffic over several configurations
    for (int c = 0; c < 8; c++) begin
      setup_ep(c[0], c == 6, c[1], 2'(c % 4));
      for (int i = 0; i < 400; i++) begin
        int r = int'($urandom % 1024);
        ev_out_rx     = r[0];
        ev_in_sent    = r[1];
        fw_pkt_ready  = r[2];
        fw_rx_ack     = r[3];
        ev_nak        = r[4] & r[5];
        fw_nak_clr    = r[6];
        ev_uframe_end = r[7] & r[8];
        ev_setup      = r[9];
        setup_byte    = 8'($urandom);
        fw_ep_reset   = (i % 97) == 50;
        fw_ep_disable = (i % 131) == 70;
        cycle();
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule